// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block lets a host run single commands on a small three-wire serial EEPROM with 64 words of 16 bits. The host writes a command register that holds a go bit, a 3-bit operation code and a 6-bit word address. It reads back a busy flag and a timeout flag. A separate 16-bit data register carries the word to be written and receives the word that a read returns. For each accepted command the controller produces the chip-select, serial clock and serial data-out sequence on the pins and samples the serial data coming back.

To write a word, the host loads the data register, writes the command register and polls until busy reads 0. To read a word, the host writes the command register, polls busy, then takes the word from the data register. Write and erase finish only when the device raises its data line to show it is ready. If the command has not finished within a fixed number of system clock cycles (30 ms worth at the default 50 MHz), the controller gives up and raises the timeout flag. Erase and write stay locked until a write-enable command has gone through. A configuration bit turns the serial port off and hands the clock and data-out pins to two host-driven output bits.

Top module: `sereep_ctl`

## Requirements
- R1: After reset, busy, timeout, chip-select, serial clock, serial data-out and the data register all read 0, and erase and write are locked.
- R2: A command-register write with go = 1 starts a command when the controller is idle and enabled and the operation code is 0 to 4. Busy then reads 1 from the next cycle. Command writes made while busy, writes with go = 0 and operation codes 5 to 7 are ignored.
- R3: Operation codes are 0 read, 1 write, 2 erase, 3 write-enable and 4 write-disable. Every frame is sent most significant bit first as a start bit 1, a 2-bit device opcode (read 10, write 01, erase 11, both enable and disable 00) and the 6-bit address. Write-enable sends address 110000 and write-disable sends 000000. A write then sends the 16 data-register bits.
- R4: While chip-select is high, the serial clock spends DIV_HALF system cycles low and DIV_HALF cycles high per bit. Serial data-out changes only while the clock is low. Serial data-in is sampled as the clock rises.
- R5: A read skips the one dummy bit that follows the address, shifts the next 16 bits into the data register most significant bit first, then drops chip-select and clears busy.
- R6: After a write or erase frame, chip-select goes low for DIV_HALF cycles and then high again. Busy stays 1 until serial data-in reads 1, and then the command ends with chip-select low and timeout 0.
- R7: While locked (after reset or after a write-disable), a write or erase command is refused. Busy stays 0 and chip-select never rises. A completed write-enable removes the lock.
- R8: If a command has not ended TIMEOUT_CYC cycles after it started, it is abandoned with chip-select low, busy 0 and timeout 1. The next started command clears timeout.
- R9: A data-register write loads the register when not busy and is ignored while busy.
- R10: With the disable bit set, chip-select is 0, the serial clock pin follows general-purpose bit 1 and serial data-out follows bit 0, and commands are not started. Configuration writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_go | input | 1 | Go bit of the written command |
| cmd_op | input | 3 | Operation code of the written command |
| cmd_addr | input | 6 | Word address of the written command |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 16 | Data register write value |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_disable | input | 1 | Serial port disable bit |
| cfg_gpo | input | 2 | General-purpose output bits (1: clock pin, 0: data pin) |
| busy | output | 1 | Command in progress |
| timeout | output | 1 | Last command was abandoned |
| dat_rdata | output | 16 | Data register contents |
| sio_cs | output | 1 | Device chip-select |
| sio_sck | output | 1 | Serial clock |
| sio_di | output | 1 | Serial data to the device |
| sio_do | input | 1 | Serial data and ready indication from the device |

## Verification
The bench pairs the controller with a behavioural device model. Random word addresses and data patterns run through write, read-back and erase, so that bit order and address decoding errors show up as wrong words rather than only as wrong timing. Directed cases cover specific conditions. Writes and erases are tried while locked, which tells refusal apart from sending. A ready signal that arrives late and one that never arrives separate correct busy holding from a timeout abort. Command, data and configuration writes are issued mid-command to show they have no effect, and the disabled mode and illegal operation codes are also exercised.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_WREN  = 3'd3,
        OP_WRDIS = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2,
        ST_READY = 2'd3
    } st_e;

    localparam logic [2:0] OP_LAST = 3'd4;

endpackage

// File: rtl/sereep_sck_div.sv
module sereep_sck_div #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!en || cnt_q == LAST) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> cnt_q == '0) else $error("divider kept counting while off"); // R4

endmodule

// File: rtl/sereep_timer.sv
module sereep_timer #(
    parameter int LIMIT = 1500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = run && (cnt_q == LAST);
        cnt_d   = cnt_q;
        if (clr)                       cnt_d = '0;
        else if (run && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TMR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0) else $error("timer not restarted"); // R8

endmodule

// File: rtl/sereep_ctl.sv
module sereep_ctl
    import sereep_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int DIV_HALF    = 4,
    parameter int TIMEOUT_CYC = 1500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_go,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              cfg_wr,
    input  logic              cfg_disable,
    input  logic [1:0]        cfg_gpo,
    output logic              busy,
    output logic              timeout,
    output logic [DATA_W-1:0] dat_rdata,
    output logic              sio_cs,
    output logic              sio_sck,
    output logic              sio_di,
    input  logic              sio_do
);
    localparam int HDR_W   = 3 + ADDR_W;
    localparam int SH_W    = HDR_W + DATA_W;
    localparam int FRM_MAX = HDR_W + 1 + DATA_W;
    localparam int BW      = $clog2(FRM_MAX + 1);

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic              busy;
        logic              tout;
        logic              wen;
        logic              cs;
        logic              sck;
        logic              cfg_dis;
        logic [1:0]        gpo;
        logic [BW-1:0]     bitc;
        logic [BW-1:0]     nbits;
        logic [SH_W-1:0]   sh;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t r_d, r_q;

    logic              tick, tmr_exp, launch, start, locked;
    logic [1:0]        f_opc;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;
    logic [BW-1:0]     f_nbits;

    sereep_sck_div #(.DIV_HALF(DIV_HALF)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (r_q.st == ST_SHIFT || r_q.st == ST_GAP),
        .tick (tick)
    );

    sereep_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (launch),
        .run    (r_q.busy),
        .expired(tmr_exp)
    );

    // frame fields for the command being written
    always_comb begin
        f_opc   = 2'b00;
        f_addr  = cmd_addr;
        f_data  = '0;
        f_nbits = BW'(HDR_W);
        case (cmd_op)
            OP_READ:  begin f_opc = 2'b10; f_nbits = BW'(FRM_MAX); end
            OP_WRITE: begin f_opc = 2'b01; f_data = r_q.data; f_nbits = BW'(SH_W); end
            OP_ERASE: f_opc = 2'b11;
            OP_WREN:  f_addr = {2'b11, {(ADDR_W-2){1'b0}}};
            default:  f_addr = '0;
        endcase
    end

    always_comb begin
        r_d    = r_q;
        start  = cmd_wr && cmd_go && !r_q.busy && !r_q.cfg_dis && (cmd_op <= OP_LAST);
        locked = (cmd_op == OP_WRITE || cmd_op == OP_ERASE) && !r_q.wen;
        launch = start && !locked;

        if (dat_wr && !r_q.busy) r_d.data = dat_wdata;
        if (cfg_wr && !r_q.busy) begin
            r_d.cfg_dis = cfg_disable;
            r_d.gpo     = cfg_gpo;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (launch) begin
                    r_d.st    = ST_SHIFT;
                    r_d.op    = op_e'(cmd_op);
                    r_d.busy  = 1'b1;
                    r_d.tout  = 1'b0;
                    r_d.cs    = 1'b1;
                    r_d.sck   = 1'b0;
                    r_d.bitc  = '0;
                    r_d.nbits = f_nbits;
                    r_d.sh    = {1'b1, f_opc, f_addr, f_data};
                    r_d.rx    = '0;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!r_q.sck) begin
                        r_d.sck = 1'b1;
                        if (r_q.op == OP_READ && r_q.bitc >= BW'(HDR_W + 1))
                            r_d.rx = {r_q.rx[DATA_W-2:0], sio_do};
                    end else begin
                        r_d.sck = 1'b0;
                        if (r_q.bitc == r_q.nbits - BW'(1)) begin
                            r_d.cs = 1'b0;
                            if (r_q.op == OP_WRITE || r_q.op == OP_ERASE) begin
                                r_d.st = ST_GAP;
                            end else begin
                                r_d.st   = ST_IDLE;
                                r_d.busy = 1'b0;
                                if (r_q.op == OP_READ)  r_d.data = r_q.rx;
                                if (r_q.op == OP_WREN)  r_d.wen  = 1'b1;
                                if (r_q.op == OP_WRDIS) r_d.wen  = 1'b0;
                            end
                        end else begin
                            r_d.bitc = r_q.bitc + BW'(1);
                            r_d.sh   = {r_q.sh[SH_W-2:0], 1'b0};
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    r_d.st = ST_READY;
                    r_d.cs = 1'b1;
                end
            end
            default: begin
                if (sio_do) begin
                    r_d.st   = ST_IDLE;
                    r_d.cs   = 1'b0;
                    r_d.busy = 1'b0;
                end
            end
        endcase

        if (tmr_exp && r_d.busy) begin
            r_d.st   = ST_IDLE;
            r_d.cs   = 1'b0;
            r_d.sck  = 1'b0;
            r_d.busy = 1'b0;
            r_d.tout = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = r_q.busy;
    assign timeout   = r_q.tout;
    assign dat_rdata = r_q.data;
    assign sio_cs    = r_q.cfg_dis ? 1'b0       : r_q.cs;
    assign sio_sck   = r_q.cfg_dis ? r_q.gpo[1] : r_q.sck;
    assign sio_di    = r_q.cfg_dis ? r_q.gpo[0] : (r_q.st == ST_SHIFT && r_q.sh[SH_W-1]);

    AST_READ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_go && !r_q.busy && !r_q.cfg_dis && cmd_op == OP_READ) |=> busy)
        else $error("read not started"); // R2

    AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && cmd_wr) |=> r_q.op == $past(r_q.op))
        else $error("command taken while busy"); // R2

    AST_DI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.cfg_dis && $past(!r_q.cfg_dis) && sio_sck && $past(sio_sck)) |-> $stable(sio_di))
        else $error("data changed while clock high"); // R4

    AST_LOCKED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_go && !r_q.busy && !r_q.wen && (cmd_op == OP_WRITE || cmd_op == OP_ERASE))
        |=> (!busy && !sio_cs)) else $error("locked command ran"); // R7

    AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_exp |=> !busy) else $error("busy after timeout"); // R8

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cfg_dis |-> !r_q.busy) else $error("busy while disabled"); // R10

endmodule

// File: tb/sim_sereep_ctl.sv
`timescale 1ns/1ps
module sim_sereep_ctl;
    localparam int DH   = 3;
    localparam int TOUT = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0, cmd_go = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [5:0]  cmd_addr = '0;
    logic        dat_wr = 1'b0;
    logic [15:0] dat_wdata = '0;
    logic        cfg_wr = 1'b0, cfg_disable = 1'b0;
    logic [1:0]  cfg_gpo = '0;
    logic        busy, timeout, sio_cs, sio_sck, sio_di;
    logic [15:0] dat_rdata;
    logic        do_r = 1'b0;

    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    sereep_ctl #(.ADDR_W(6), .DATA_W(16), .DIV_HALF(DH), .TIMEOUT_CYC(TOUT)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_go(cmd_go), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .dat_wr(dat_wr), .dat_wdata(dat_wdata), .cfg_wr(cfg_wr),
        .cfg_disable(cfg_disable), .cfg_gpo(cfg_gpo), .busy(busy), .timeout(timeout),
        .dat_rdata(dat_rdata), .sio_cs(sio_cs), .sio_sck(sio_sck), .sio_di(sio_di),
        .sio_do(do_r)
    );

    // ---------------- device model ----------------
    logic [15:0] mem [64];
    logic [25:0] fbits = '0, last_frame = '0;
    logic [5:0]  rd_addr = '0;
    int nrise = 0, last_n = 0, cs_rises = 0, ready_delay = 12, rdy_cnt = 0;
    int hi_len = 0, lo_len = 0, hmin = 999, hmax = 0, lmin = 999, lmax = 0;
    int gap_len = 0, last_gap = 0, di_err = 0;
    bit ready_mode = 0, pend_ready = 0;
    logic p_cs = 0, p_sck = 0, p_di = 0;

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0413) ^ 16'hA5C3;
        forever begin
            @(negedge clk);
            if (sio_cs && !p_cs) begin
                cs_rises++;
                if (pend_ready) begin ready_mode = 1; rdy_cnt = ready_delay; last_gap = gap_len; end
                else begin nrise = 0; fbits = '0; lo_len = 0; end
            end
            if (!sio_cs && p_cs) begin
                if (ready_mode) begin ready_mode = 0; pend_ready = 0; end
                else begin
                    last_frame = fbits; last_n = nrise;
                    if (nrise == 25 && fbits[24:22] == 3'b101) begin
                        mem[fbits[21:16]] = fbits[15:0]; pend_ready = 1;
                    end
                    if (nrise == 9 && fbits[8:6] == 3'b111) begin
                        mem[fbits[5:0]] = 16'hFFFF; pend_ready = 1;
                    end
                end
                do_r = 1'b0; gap_len = 0;
            end
            if (!sio_cs) gap_len++;
            if (sio_cs && !ready_mode) begin
                if (sio_sck && !p_sck) begin
                    if (lo_len < lmin) lmin = lo_len;
                    if (lo_len > lmax) lmax = lo_len;
                    hi_len = 1;
                    nrise++;
                    fbits = {fbits[24:0], sio_di};
                    if (nrise == 9 && fbits[7:6] == 2'b10) begin do_r = 1'b0; rd_addr = fbits[5:0]; end
                    if (nrise >= 10 && nrise <= 25 && last_op_read(fbits, nrise))
                        do_r = mem[rd_addr][25 - nrise];
                end else if (sio_sck) hi_len++;
                else if (p_sck) begin
                    if (hi_len < hmin) hmin = hi_len;
                    if (hi_len > hmax) hmax = hi_len;
                    lo_len = 1;
                end else lo_len++;
                if (sio_sck && p_sck && sio_di != p_di) di_err++;
            end
            if (sio_cs && ready_mode && ready_delay >= 0) begin
                if (rdy_cnt == 0) do_r = 1'b1;
                else rdy_cnt--;
            end
            p_cs = sio_cs; p_sck = sio_sck; p_di = sio_di;
        end
    end

    function automatic bit last_op_read(logic [25:0] f, int n);
        logic [25:0] h = f >> (n - 9);
        return h[8:6] == 3'b110;
    endfunction

    // ---------------- expected values ----------------
    function automatic logic [25:0] exp_frame(int op, logic [5:0] a, logic [15:0] d);
        case (op)
            0:       return {1'b1, 2'b10, a, 17'b0};
            1:       return {1'b0, 1'b1, 2'b01, a, d};
            2:       return {17'b0, 1'b1, 2'b11, a};
            3:       return {17'b0, 1'b1, 2'b00, 6'b110000};
            default: return {17'b0, 1'b1, 2'b00, 6'b000000};
        endcase
    endfunction

    function automatic int exp_n(int op);
        return (op == 0) ? 26 : (op == 1) ? 25 : 9;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmd(input int op, input logic [5:0] a, input bit go = 1);
        @(negedge clk);
        cmd_wr = 1; cmd_go = go; cmd_op = 3'(op); cmd_addr = a;
        @(negedge clk);
        cmd_wr = 0; cmd_go = 0;
    endtask

    task automatic load(input logic [15:0] d);
        @(negedge clk); dat_wr = 1; dat_wdata = d;
        @(negedge clk); dat_wr = 0;
    endtask

    task automatic cfg(input bit dis, input logic [1:0] g);
        @(negedge clk); cfg_wr = 1; cfg_disable = dis; cfg_gpo = g;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic frame_chk(input int op, input logic [5:0] a, input logic [15:0] d, input string req);
        chk(last_frame == exp_frame(op, a, d), req, 32'(last_frame), 32'(exp_frame(op, a, d)));
        chk(last_n == exp_n(op), req, last_n, exp_n(op));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n, rises;
        logic [5:0] a;
        logic [15:0] d, e;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({busy, timeout, sio_cs, sio_sck, sio_di} == 5'b0, "R1", {busy, timeout, sio_cs, sio_sck, sio_di}, 0);
        chk(dat_rdata == 16'h0, "R1", dat_rdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 read while locked, frame R3
        e = mem[6'h2A];
        cmd(0, 6'h2A);
        chk(busy == 1'b1, "R2", busy, 1);
        wait_idle(n);
        chk(dat_rdata == e, "R5", dat_rdata, e);
        chk(sio_cs == 1'b0, "R5", sio_cs, 0);
        frame_chk(0, 6'h2A, 0, "R3");

        // R7 write and erase refused after reset
        rises = cs_rises;
        load(16'h1234);
        cmd(1, 6'h05);
        chk(busy == 1'b0, "R7", busy, 0);
        cmd(2, 6'h06);
        chk(busy == 1'b0, "R7", busy, 0);
        repeat (20) @(negedge clk);
        chk(cs_rises == rises, "R7", cs_rises, rises);

        // R2 go=0 and illegal code ignored
        cmd(0, 6'h01, 0);
        chk(busy == 1'b0, "R2", busy, 0);
        cmd(6, 6'h01);
        chk(busy == 1'b0, "R2", busy, 0);
        repeat (10) @(negedge clk);
        chk(cs_rises == rises, "R2", cs_rises, rises);

        // write-enable R3 R7
        cmd(3, 6'h00);
        wait_idle(n);
        frame_chk(3, 6'h00, 0, "R3");

        // random writes and read-backs R3 R6 R5
        for (int k = 0; k < 6; k++) begin
            a = 6'($urandom);
            d = 16'($urandom);
            e = mem[a ^ 6'h01];
            load(d);
            cmd(1, a);
            cmd(2, a ^ 6'h01);           // R2 ignored while busy
            @(negedge clk); dat_wr = 1; dat_wdata = ~d;   // R9 ignored while busy
            @(negedge clk); dat_wr = 0;
            wait_idle(n);
            frame_chk(1, a, d, "R3");
            chk(mem[a] == d, "R6", mem[a], d);
            chk(mem[a ^ 6'h01] == e, "R2", mem[a ^ 6'h01], e);
            chk(dat_rdata == d, "R9", dat_rdata, d);
            chk(timeout == 1'b0, "R6", timeout, 0);
            chk(last_gap == DH, "R6", last_gap, DH);
            mem[a] = ~d ^ 16'h0F0F;
            e = mem[a];
            cmd(0, a);
            wait_idle(n);
            chk(dat_rdata == e, "R5", dat_rdata, e);
        end

        // erase R6
        a = 6'h3F;
        cmd(2, a);
        wait_idle(n);
        frame_chk(2, a, 0, "R3");
        chk(mem[a] == 16'hFFFF, "R6", mem[a], 16'hFFFF);

        // late ready holds busy R6
        ready_delay = 200;
        load(16'hBEEF);
        cmd(1, 6'h10);
        wait_idle(n);
        chk(n > 200 && n < TOUT, "R6", n, 200);
        chk(timeout == 1'b0, "R6", timeout, 0);

        // no ready: timeout R8
        ready_delay = -1;
        cmd(1, 6'h11);
        wait_idle(n);
        chk(n >= TOUT - 2 && n <= TOUT + 1, "R8", n, TOUT);
        chk(timeout == 1'b1, "R8", timeout, 1);
        chk(sio_cs == 1'b0, "R8", sio_cs, 0);
        ready_delay = 12;
        cmd(0, 6'h11);
        chk(timeout == 1'b0, "R8", timeout, 0);
        wait_idle(n);

        // write-disable then refusal R7
        cmd(4, 6'h00);
        wait_idle(n);
        frame_chk(4, 6'h00, 0, "R3");
        rises = cs_rises;
        cmd(1, 6'h12);
        chk(busy == 1'b0, "R7", busy, 0);
        repeat (10) @(negedge clk);
        chk(cs_rises == rises, "R7", cs_rises, rises);

        // serial timing R4
        chk(hmin == DH && hmax == DH, "R4", hmax, DH);
        chk(lmin == DH && lmax == DH, "R4", lmax, DH);
        chk(di_err == 0, "R4", di_err, 0);

        // disable mode R10
        cfg(1, 2'b10);
        chk({sio_cs, sio_sck, sio_di} == 3'b010, "R10", {sio_cs, sio_sck, sio_di}, 3'b010);
        cmd(0, 6'h03);
        chk(busy == 1'b0, "R10", busy, 0);
        cfg(1, 2'b01);
        chk({sio_cs, sio_sck, sio_di} == 3'b001, "R10", {sio_cs, sio_sck, sio_di}, 3'b001);
        cfg(0, 2'b11);
        e = mem[6'h04];
        cmd(0, 6'h04);
        cfg(1, 2'b11);                   // ignored while busy
        wait_idle(n);
        chk(dat_rdata == e, "R10", dat_rdata, e);
        chk({sio_sck, sio_di} == 2'b00, "R10", {sio_sck, sio_di}, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule